// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the register state of a 32-bit processor core. Software always sees sixteen registers, numbered 0 to 15. Index 15 is the program counter, index 14 is the link register and index 13 is the stack pointer. The operating mode decides which physical register stands behind an index:

- The fast-interrupt mode replaces indices 8 to 14 with a private set.
- The interrupt, supervisor, abort and undefined modes each replace only indices 13 and 14.
- The user and system modes use the shared set.

The core drives a 3-bit mode code, two read addresses, one general write port and a fetch-advance strobe. It also drives a link strobe that stores the return address on a branch-with-link. The block returns two read words and the current program counter. Reads are combinational. Writes land on the rising clock edge.

The mode code is a fixed enumeration with the following states:

| Code | Mode |
|------|------|
| 0 | user |
| 1 | system |
| 2 | fast interrupt |
| 3 | interrupt |
| 4 | supervisor |
| 5 | abort |
| 6 | undefined |
| 7 | reserved, behaves as user |

The mode code is an input, so there are no transitions inside the block. A change of the mode code changes the mapping at once.

Top module: `banked_regfile`

## Requirements
- R1: After reset, every general register reads zero in every mode and the program counter equals RESET_PC (default 0).
- R2: Indices 0 to 7 name the same physical registers in all modes. A write in any mode is seen in every other mode.
- R3: In mode 2 (fast interrupt), indices 8 to 14 name a private set. Writes in mode 2 are not seen by other modes, and writes by other modes to those indices are not seen in mode 2.
- R4: Modes 3 to 6 each have a private index 13 and a private index 14, separate from each other and from the shared set. Their indices 8 to 12 are the shared ones.
- R5: Mode 0 (user) and mode 1 (system) share all registers. Mode code 7 behaves as mode 0.
- R6: A read of a register that is being written in the same cycle returns the old value. The new value is readable from the cycle after the write edge.
- R7: With fetch_adv high and no program-counter write, the program counter increases by 4 at each edge. With fetch_adv low and no write, it holds.
- R8: A general write to index 15 loads the program counter with the data's two low bits cleared, and overrides the increment in that cycle.
- R9: With link_en high, the current mode's index 14 is loaded with the program counter plus 4. This takes priority over a general write to index 14 in the same cycle.
- R10: Reading index 15 on either port returns the current program counter, whose two low bits are always zero.
- R11: The two read ports are independent. Equal addresses always give equal data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Operating mode code (0 user .. 6 undefined, 7 as user) |
| ra_addr | input | 4 | Read port A index |
| ra_data | output | XLEN | Read port A data |
| rb_addr | input | 4 | Read port B index |
| rb_data | output | XLEN | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write index (15 loads the program counter) |
| wr_data | input | XLEN | General write data |
| link_en | input | 1 | Store program counter plus 4 into current index 14 |
| fetch_adv | input | 1 | Advance program counter by one instruction |
| pc_o | output | XLEN | Current program counter |

## Verification
A table of write-then-read pairs stores a value in one mode and reads an index back in another. The pairs cover each banking class: shared low indices, the fast-interrupt upper set, the single-pair modes, and user against system and the reserved code. A result that differs from the expected one shows which class has a wrong mapping. Directed sequences then separate same-cycle read-before-write from read-after-write. They also separate increment, hold and load of the program counter, and check that the link write beats a general write to index 14.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic [2:0] {
        M_USR = 3'd0,
        M_SYS = 3'd1,
        M_FIQ = 3'd2,
        M_IRQ = 3'd3,
        M_SVC = 3'd4,
        M_ABT = 3'd5,
        M_UND = 3'd6,
        M_RSV = 3'd7
    } mode_e;

    localparam int NIDX   = 16;
    localparam int IDX_W  = $clog2(NIDX);

    localparam logic [IDX_W-1:0] PC_IDX  = IDX_W'(15);
    localparam logic [IDX_W-1:0] LR_IDX  = IDX_W'(14);
    localparam logic [IDX_W-1:0] SP_IDX  = IDX_W'(13);
    localparam logic [IDX_W-1:0] FIQ_LO  = IDX_W'(8);

    // shared set holds indices 0..14
    localparam int FIQ_BASE   = int'(PC_IDX);
    localparam int NFIQ       = int'(LR_IDX) - int'(FIQ_LO) + 1;
    localparam int PAIR_BASE  = FIQ_BASE + NFIQ;
    localparam int NPAIRMODES = int'(M_UND) - int'(M_IRQ) + 1;
    localparam int NPHYS      = PAIR_BASE + 2 * NPAIRMODES;
    localparam int PW         = $clog2(NPHYS);

endpackage

// File: rtl/rf_map.sv
module rf_map
    import rf_pkg::*;
(
    input  mode_e                mode,
    input  logic [IDX_W-1:0]     idx,
    output logic [PW-1:0]        phys
);

    always_comb begin
        phys = PW'(idx);
        unique case (mode)
            M_FIQ: begin
                if (idx >= FIQ_LO && idx <= LR_IDX)
                    phys = PW'(FIQ_BASE) + PW'(idx) - PW'(FIQ_LO);
            end
            M_IRQ, M_SVC, M_ABT, M_UND: begin
                if (idx == SP_IDX || idx == LR_IDX)
                    phys = PW'(PAIR_BASE)
                         + PW'({3'(mode - M_IRQ), 1'b0})
                         + PW'(idx - SP_IDX);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rf_pc.sv
module rf_pc #(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] load_val,
    input  logic            adv,
    output logic [XLEN-1:0] pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;

    always_comb begin
        if (load)
            pc_d = {load_val[XLEN-1:2], 2'b00};
        else if (adv)
            pc_d = pc_q + STEP;
        else
            pc_d = pc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= {RESET_PC[XLEN-1:2], 2'b00};
        else
            pc_q <= pc_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/rf_store.sv
module rf_store
    import rf_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NRD  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wa_en,
    input  logic [PW-1:0]             wa_idx,
    input  logic [XLEN-1:0]           wa_data,
    input  logic                      wl_en,
    input  logic [PW-1:0]             wl_idx,
    input  logic [XLEN-1:0]           wl_data,
    input  logic [NRD-1:0][PW-1:0]    rd_idx,
    output logic [NRD-1:0][XLEN-1:0]  rd_data
);

    logic [XLEN-1:0] regs [NPHYS];

    // link port assigned last so it wins on a shared target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++)
                regs[i] <= '0;
        end else begin
            if (wa_en) regs[wa_idx] <= wa_data;
            if (wl_en) regs[wl_idx] <= wl_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_idx[p] < PW'(NPHYS)) ? regs[rd_idx[p]] : '0;
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic [3:0]       ra_addr,
    output logic [XLEN-1:0]  ra_data,
    input  logic [3:0]       rb_addr,
    output logic [XLEN-1:0]  rb_data,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic             link_en,
    input  logic             fetch_adv,
    output logic [XLEN-1:0]  pc_o
);

    localparam int NRD   = 2;
    localparam int NMAP  = NRD + 2;
    localparam int P_WR  = NRD;
    localparam int P_LNK = NRD + 1;

    mode_e mode;
    assign mode = mode_e'(mode_i);

    logic [NMAP-1:0][IDX_W-1:0] log_idx;
    logic [NMAP-1:0][PW-1:0]    phy_idx;
    logic [NRD-1:0][XLEN-1:0]   st_rd;
    logic [XLEN-1:0]            pc_q;
    logic                       wr_pc;

    assign log_idx[0]     = ra_addr;
    assign log_idx[1]     = rb_addr;
    assign log_idx[P_WR]  = wr_addr;
    assign log_idx[P_LNK] = LR_IDX;

    for (genvar m = 0; m < NMAP; m++) begin : g_map
        rf_map u_map (
            .mode (mode),
            .idx  (log_idx[m]),
            .phys (phy_idx[m])
        );
    end

    assign wr_pc = wr_en && (wr_addr == PC_IDX);

    rf_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_pc),
        .load_val (wr_data),
        .adv      (fetch_adv),
        .pc       (pc_q)
    );

    rf_store #(.XLEN(XLEN), .NRD(NRD)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wr_en && !wr_pc),
        .wa_idx  (phy_idx[P_WR]),
        .wa_data (wr_data),
        .wl_en   (link_en),
        .wl_idx  (phy_idx[P_LNK]),
        .wl_data (pc_q + XLEN'(4)),
        .rd_idx  (phy_idx[NRD-1:0]),
        .rd_data (st_rd)
    );

    assign ra_data = (ra_addr == PC_IDX) ? pc_q : st_rd[0];
    assign rb_data = (rb_addr == PC_IDX) ? pc_q : st_rd[1];
    assign pc_o    = pc_q;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      mode_i,
    input logic [3:0]      ra_addr,
    input logic [XLEN-1:0] ra_data,
    input logic [3:0]      rb_addr,
    input logic [XLEN-1:0] rb_data,
    input logic            wr_en,
    input logic [3:0]      wr_addr,
    input logic [XLEN-1:0] wr_data,
    input logic            link_en,
    input logic            fetch_adv,
    input logic [XLEN-1:0] pc_o
);

    logic pcw;
    assign pcw = wr_en && (wr_addr == 4'd15);

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);                                            // R10

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv && !pcw) |=> pc_o == $past(pc_o) + XLEN'(4));        // R7

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_adv && !pcw) |=> $stable(pc_o));                        // R7

    AST_PC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        pcw |=> pc_o == {$past(wr_data[XLEN-1:2]), 2'b00});             // R8

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        link_en ##1 (ra_addr == 4'd14 && mode_i == $past(mode_i))
        |-> ra_data == $past(pc_o) + XLEN'(4));                         // R9

    AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == rb_addr) |-> ra_data == rb_data);                   // R11

endmodule

bind banked_regfile banked_regfile_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .ra_addr   (ra_addr),
    .ra_data   (ra_data),
    .rb_addr   (rb_addr),
    .rb_data   (rb_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .link_en   (link_en),
    .fetch_adv (fetch_adv),
    .pc_o      (pc_o)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  mode_i;
    logic [3:0]  ra_addr, rb_addr, wr_addr;
    logic [31:0] ra_data, rb_data, wr_data, pc_o;
    logic        wr_en, link_en, fetch_adv;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .ra_addr(ra_addr), .ra_data(ra_data),
        .rb_addr(rb_addr), .rb_data(rb_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .link_en(link_en), .fetch_adv(fetch_adv), .pc_o(pc_o)
    );

    typedef struct packed {
        logic [2:0]  wm;
        logic [3:0]  wa;
        logic [31:0] wd;
        logic [2:0]  rm;
        logic [3:0]  rad;
        logic [31:0] ex;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 4'd3,  32'h0000_00A3, 3'd2, 4'd3,  32'h0000_00A3, 4'd2}, // R2
        '{3'd4, 4'd7,  32'h0000_00B7, 3'd0, 4'd7,  32'h0000_00B7, 4'd2}, // R2
        '{3'd0, 4'd8,  32'h0000_00C8, 3'd2, 4'd8,  32'h0000_0000, 4'd3}, // R3
        '{3'd2, 4'd8,  32'h0000_00D8, 3'd0, 4'd8,  32'h0000_00C8, 4'd3}, // R3
        '{3'd2, 4'd12, 32'h0000_00DC, 3'd2, 4'd12, 32'h0000_00DC, 4'd3}, // R3
        '{3'd0, 4'd13, 32'h0000_0E13, 3'd3, 4'd13, 32'h0000_0000, 4'd4}, // R4
        '{3'd3, 4'd13, 32'h0000_0F13, 3'd0, 4'd13, 32'h0000_0E13, 4'd4}, // R4
        '{3'd4, 4'd14, 32'h0000_1414, 3'd5, 4'd14, 32'h0000_0000, 4'd4}, // R4
        '{3'd6, 4'd13, 32'h0000_5513, 3'd6, 4'd13, 32'h0000_5513, 4'd4}, // R4
        '{3'd5, 4'd10, 32'h0000_AA10, 3'd0, 4'd10, 32'h0000_AA10, 4'd4}, // R4
        '{3'd1, 4'd13, 32'h0000_9913, 3'd0, 4'd13, 32'h0000_9913, 4'd5}, // R5
        '{3'd0, 4'd14, 32'h0000_7714, 3'd7, 4'd14, 32'h0000_7714, 4'd5}, // R5
        '{3'd2, 4'd14, 32'h0000_0F14, 3'd4, 4'd14, 32'h0000_1414, 4'd3}, // R3
        '{3'd3, 4'd9,  32'h0000_00B9, 3'd2, 4'd9,  32'h0000_0000, 4'd3}  // R3
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; link_en = 0; fetch_adv = 0;
    endtask

    task automatic write_reg(input logic [2:0] m, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        mode_i = m; wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        idle();
    endtask

    task automatic read_a(input logic [2:0] m, input logic [3:0] a);
        mode_i = m; ra_addr = a; rb_addr = a;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_i = 0; ra_addr = 0; rb_addr = 0; wr_addr = 0; wr_data = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        read_a(3'd0, 4'd0);  check("R1 usr r0", ra_data, 32'h0);
        read_a(3'd2, 4'd14); check("R1 fiq r14", ra_data, 32'h0);
        read_a(3'd4, 4'd13); check("R1 svc r13", ra_data, 32'h0);
        check("R1 pc", pc_o, 32'h0);

        // table of write-then-read pairs
        for (int i = 0; i < NV; i++) begin
            write_reg(VEC[i].wm, VEC[i].wa, VEC[i].wd);
            read_a(VEC[i].rm, VEC[i].rad);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), ra_data, VEC[i].ex);
        end

        // R11 independent ports
        @(negedge clk);
        mode_i = 3'd0; ra_addr = 4'd3; rb_addr = 4'd8; #1;
        check("R11 port a", ra_data, 32'h0000_00A3);
        check("R11 port b", rb_data, 32'h0000_00C8);

        // R6 read-during-write
        @(negedge clk);
        mode_i = 3'd0; wr_en = 1; wr_addr = 4'd5; wr_data = 32'h55; ra_addr = 4'd5; #1;
        check("R6 old value", ra_data, 32'h0);
        @(negedge clk);
        idle(); #1;
        check("R6 new value", ra_data, 32'h55);

        // R7 advance and hold
        @(negedge clk);
        fetch_adv = 1;
        repeat (3) @(negedge clk);
        fetch_adv = 0; #1;
        check("R7 advance", pc_o, 32'd12);
        repeat (2) @(negedge clk);
        check("R7 hold", pc_o, 32'd12);

        // R8 load overrides increment, low bits cleared; R10 read of 15
        @(negedge clk);
        wr_en = 1; wr_addr = 4'd15; wr_data = 32'h0000_1003; fetch_adv = 1;
        @(negedge clk);
        idle();
        check("R8 pc load", pc_o, 32'h0000_1000);
        read_a(3'd4, 4'd15);
        check("R10 read pc a", ra_data, 32'h0000_1000);
        check("R10 read pc b", rb_data, 32'h0000_1000);

        // R9 branch with link in supervisor mode
        @(negedge clk);
        mode_i = 3'd4; link_en = 1; wr_en = 1; wr_addr = 4'd15;
        wr_data = 32'h0000_2000; fetch_adv = 1;
        @(negedge clk);
        idle();
        read_a(3'd4, 4'd14);
        check("R9 svc link", ra_data, 32'h0000_1004);
        check("R9 pc target", pc_o, 32'h0000_2000);
        read_a(3'd0, 4'd14);
        check("R9 usr r14 untouched", ra_data, 32'h0000_7714);

        // R9 link beats general write to 14
        @(negedge clk);
        mode_i = 3'd3; link_en = 1; wr_en = 1; wr_addr = 4'd14; wr_data = 32'hDEAD_BEEF;
        @(negedge clk);
        idle();
        read_a(3'd3, 4'd14);
        check("R9 link priority", ra_data, 32'h0000_2004);

        // R1 reset clears state again
        do_reset();
        read_a(3'd2, 4'd8);  check("R1 fiq r8 cleared", ra_data, 32'h0);
        read_a(3'd0, 4'd3);  check("R1 usr r3 cleared", ra_data, 32'h0);
        check("R1 pc cleared", pc_o, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule